// File: doc/BRIEF.md
# Horizontal Blanking Flag Counter

This block keeps a saturating sample count along a video line and raises two markers when the count hits positions chosen by software. The count restarts at the end of each horizontal blanking interval, when the sampled blanking input goes from high to low. Both markers drop at that same moment. Each marker has its own programmable terminal count. This lets a downstream stage find, for example, the start of active picture and a guard position near the end of the line without any counting logic of its own.

The block also sits on a four-channel data path. While the blanking input is high, each channel's output carries a programmable blanking level. While it is low, the input sample passes through. Every output is registered.

Configuration uses a simple write port. Address bit 2 selects the bank: 0 selects the terminal-count bank and 1 selects the blanking-level bank. Bits 1:0 select the entry. Addresses 0 and 1 hold the terminal counts for marker 0 and marker 1. Addresses 4 to 7 hold the levels for channels 0 to 3. Addresses 2 and 3 are unused.

Top module: `hblank_marker`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, both flags, the counter and `ch_out` go to zero. Both terminal counts go to all ones and all blanking levels go to zero.
- R2: The counter is 20 bits wide. It starts at 0 after a clearing event and adds one at each rising edge where `sample_en` is high. A flag rises at the edge after one where the counter equals that flag's terminal count, so a terminal count of 0 sets the flag one edge after the clear.
- R3: `flag_o[0]` follows terminal count 0 (address 0) and `flag_o[1]` follows terminal count 1 (address 1), independently of each other.
- R4: Once a flag is set, it stays high until the next reset or the next clearing event.
- R5: A clearing event is an edge where `blank_in` was high at the previous edge and is low at this one. At that edge the counter and both flags go to zero. This takes priority over an increment and over a terminal-count match at the same edge.
- R6: A rising edge of `blank_in`, and blanking that stays high, clear neither the counter nor the flags.
- R7: The counter stops at its maximum value (all ones) instead of wrapping to zero.
- R8: A terminal-count write is used for comparison from the following edge on. The write does not change either flag.
- R9: Channel k occupies bits [13k+12:13k] of `ch_in` and `ch_out`. After an edge with `blank_in` high, channel k shows its blanking level. After an edge with `blank_in` low, it shows the channel-k input sampled at that edge.
- R10: A blanking-level write (address 4+k, data bits 12:0) appears on the outputs from the following edge on.
- R11: Writes to addresses 2 and 3 change no register and no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| blank_in | input | 1 | Horizontal blanking, high while blanking |
| sample_en | input | 1 | One valid core sample this cycle |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration address (bank bit 2, entry bits 1:0) |
| cfg_wdata | input | 20 | Configuration write data |
| ch_in | input | 52 | Four 13-bit channel samples |
| ch_out | output | 52 | Four registered 13-bit channel results |
| flag_o | output | 2 | Terminal-count markers |

## Verification
The bench targets several corner cases, each with the failure it would expose:

- **Clear coinciding with a match.** A falling blanking edge lands on the exact edge where the count equals a freshly written terminal count. A design that lets the match win leaves the flag set into the new line.
- **Terminal count of zero.** A zero terminal count is used right after a clear. An off-by-one compare would miss it or set it a cycle late.
- **Writes while flags are set.** Terminal counts are rewritten while markers are high. A design that clears on write drops the marker.
- **Saturation.** A narrow instance drives the counter past its maximum after moving a terminal count to a value already passed. A wrapping counter would re-cross that value and raise the marker.
- **Data path.** Level writes during blanking and writes to the unused addresses check the output timing of the data path and that unused writes leave it unchanged.

// File: rtl/hbm_pkg.sv
// Shared definitions for the horizontal blanking marker block.
// Assumes: configuration address = {bank bit, entry index}.
package hbm_pkg;

    // Bank selected by the top configuration address bit.
    typedef enum logic {
        HBM_BANK_TC  = 1'b0,
        HBM_BANK_LVL = 1'b1
    } hbm_bank_e;

endpackage

// File: rtl/hbm_cfg_regs.sv
// Configuration storage: one terminal count per marker, one blanking level per channel.
// Assumes: WDATA_W >= CNT_W and WDATA_W >= DATA_W; unused entry indexes are ignored.
module hbm_cfg_regs
    import hbm_pkg::*;
#(
    parameter int CNT_W     = 20,
    parameter int DATA_W    = 13,
    parameter int NUM_FLAGS = 2,
    parameter int NUM_CH    = 4,
    parameter int SEL_W     = 2,
    parameter int WDATA_W   = 20
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                cfg_we,
    input  logic [SEL_W:0]                      cfg_addr,
    input  logic [WDATA_W-1:0]                  cfg_wdata,
    output logic [NUM_FLAGS-1:0][CNT_W-1:0]     tc,
    output logic [NUM_CH-1:0][DATA_W-1:0]       lvl
);

    hbm_bank_e        bank;
    logic [SEL_W-1:0] idx;

    assign bank = hbm_bank_e'(cfg_addr[SEL_W]);
    assign idx  = cfg_addr[SEL_W-1:0];

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_tc
        logic [CNT_W-1:0] tc_r;
        // Hold terminal count i; reset parks it at the counter maximum.
        always_ff @(posedge clk) begin
            if (!rst_n)
                tc_r <= '1;
            else if (cfg_we && bank == HBM_BANK_TC && idx == SEL_W'(i))
                tc_r <= cfg_wdata[CNT_W-1:0];
        end
        assign tc[i] = tc_r;
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_lvl
        logic [DATA_W-1:0] lvl_r;
        // Hold the blanking level of channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                lvl_r <= '0;
            else if (cfg_we && bank == HBM_BANK_LVL && idx == SEL_W'(c))
                lvl_r <= cfg_wdata[DATA_W-1:0];
        end
        assign lvl[c] = lvl_r;
    end

endmodule

// File: rtl/hbm_line_counter.sv
// Line position counter: registers blanking, detects its falling edge and
// counts valid samples, saturating at all ones.
// Assumes: the clear pulse is used in the same cycle by the marker bank.
module hbm_line_counter #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             blank_in,
    input  logic             sample_en,
    output logic [CNT_W-1:0] count,
    output logic             blank_q,
    output logic             clr
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    // Keep last sampled blanking level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            blank_q <= 1'b0;
        else
            blank_q <= blank_in;
    end

    assign clr = blank_q & ~blank_in;

    // Count valid samples; clear wins, maximum holds.
    always_ff @(posedge clk) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (sample_en && count != CNT_MAX)
            count <= count + 1'b1;
    end

endmodule

// File: rtl/hbm_flag_bank.sv
// Sticky markers: each sets when the count equals its terminal count and
// drops only on reset or the blanking clear pulse.
// Assumes: tc is taken as held before the edge (writes act one edge later).
module hbm_flag_bank #(
    parameter int CNT_W     = 20,
    parameter int NUM_FLAGS = 2
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            clr,
    input  logic [CNT_W-1:0]                count,
    input  logic [NUM_FLAGS-1:0][CNT_W-1:0] tc,
    output logic [NUM_FLAGS-1:0]            flags
);

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        logic flag_r;
        // Set on match, hold, clear has priority.
        always_ff @(posedge clk) begin
            if (!rst_n)
                flag_r <= 1'b0;
            else if (clr)
                flag_r <= 1'b0;
            else if (count == tc[i])
                flag_r <= 1'b1;
        end
        assign flags[i] = flag_r;
    end

endmodule

// File: rtl/hbm_blank_mux.sv
// Per-channel output register selecting the blanking level or the live sample.
// Assumes: channel c sits at bits [c*DATA_W +: DATA_W] of the packed buses.
module hbm_blank_mux #(
    parameter int DATA_W = 13,
    parameter int NUM_CH = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          blank_in,
    input  logic [NUM_CH-1:0][DATA_W-1:0] lvl,
    input  logic [NUM_CH*DATA_W-1:0]      ch_in,
    output logic [NUM_CH*DATA_W-1:0]      ch_out
);

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [DATA_W-1:0] out_r;
        // Register level or sample for channel c.
        always_ff @(posedge clk) begin
            if (!rst_n)
                out_r <= '0;
            else
                out_r <= blank_in ? lvl[c] : ch_in[c*DATA_W +: DATA_W];
        end
        assign ch_out[c*DATA_W +: DATA_W] = out_r;
    end

endmodule

// File: rtl/hblank_marker.sv
// Top of the horizontal blanking marker: configuration registers, line
// counter, sticky marker bank and blanking data replacement.
// Assumes: NUM_FLAGS and NUM_CH each fit in SEL_W index bits.
module hblank_marker #(
    parameter int CNT_W     = 20,
    parameter int DATA_W    = 13,
    parameter int NUM_FLAGS = 2,
    parameter int NUM_CH    = 4,
    parameter int SEL_W     = 2,
    localparam int ADDR_W   = SEL_W + 1,
    localparam int WDATA_W  = (CNT_W > DATA_W) ? CNT_W : DATA_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       blank_in,
    input  logic                       sample_en,
    input  logic                       cfg_we,
    input  logic [ADDR_W-1:0]          cfg_addr,
    input  logic [WDATA_W-1:0]         cfg_wdata,
    input  logic [NUM_CH*DATA_W-1:0]   ch_in,
    output logic [NUM_CH*DATA_W-1:0]   ch_out,
    output logic [NUM_FLAGS-1:0]       flag_o
);

    logic [NUM_FLAGS-1:0][CNT_W-1:0] tc_w;
    logic [NUM_CH-1:0][DATA_W-1:0]   lvl_w;
    logic [CNT_W-1:0]                count_w;
    logic                            blank_q_w;
    logic                            clr_w;

    hbm_cfg_regs #(
        .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS),
        .NUM_CH(NUM_CH), .SEL_W(SEL_W), .WDATA_W(WDATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .tc(tc_w), .lvl(lvl_w)
    );

    hbm_line_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .blank_in(blank_in), .sample_en(sample_en),
        .count(count_w), .blank_q(blank_q_w), .clr(clr_w)
    );

    hbm_flag_bank #(.CNT_W(CNT_W), .NUM_FLAGS(NUM_FLAGS)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(clr_w), .count(count_w),
        .tc(tc_w), .flags(flag_o)
    );

    hbm_blank_mux #(.DATA_W(DATA_W), .NUM_CH(NUM_CH)) u_mux (
        .clk(clk), .rst_n(rst_n), .blank_in(blank_in), .lvl(lvl_w),
        .ch_in(ch_in), .ch_out(ch_out)
    );

endmodule

// File: rtl/hbm_checker.sv
// Property checker for hblank_marker, attached by bind.
module hbm_checker #(
    parameter int CNT_W     = 20,
    parameter int DATA_W    = 13,
    parameter int NUM_FLAGS = 2,
    parameter int NUM_CH    = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            blank_in,
    input logic                            sample_en,
    input logic [NUM_CH*DATA_W-1:0]        ch_in,
    input logic [NUM_CH*DATA_W-1:0]        ch_out,
    input logic [NUM_FLAGS-1:0]            flag_o,
    input logic [CNT_W-1:0]                count,
    input logic                            blank_q,
    input logic [NUM_FLAGS-1:0][CNT_W-1:0] tc
);

    // R1
    rst_clears_chk: assert property (@(posedge clk)
        !rst_n |=> (flag_o == '0 && ch_out == '0 && count == '0));

    // R5
    fall_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (blank_q && !blank_in) |=> (flag_o == '0 && count == '0));

    // R2
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && !(blank_q && !blank_in) && !(&count))
        |=> count == CNT_W'($past(count) + 1'b1));

    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((&count) && !(blank_q && !blank_in)) |=> (&count));

    // R9
    pass_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !blank_in |=> ch_out == $past(ch_in));

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_fchk
        // R4
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_o[i] && !(blank_q && !blank_in)) |=> flag_o[i]);
        // R3
        flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (count == tc[i] && !(blank_q && !blank_in)) |=> flag_o[i]);
    end

endmodule

bind hblank_marker hbm_checker #(
    .CNT_W(CNT_W), .DATA_W(DATA_W), .NUM_FLAGS(NUM_FLAGS), .NUM_CH(NUM_CH)
) chk (
    .clk(clk), .rst_n(rst_n), .blank_in(blank_in), .sample_en(sample_en),
    .ch_in(ch_in), .ch_out(ch_out), .flag_o(flag_o), .count(count_w),
    .blank_q(blank_q_w), .tc(tc_w)
);

// File: tb/hblank_marker_test.sv
module hblank_marker_test;

    localparam int CW = 20;
    localparam int DW = 13;
    localparam int NC = 4;
    localparam logic [CW-1:0] MAXC = '1;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic              rst_n = 1'b0, blank = 1'b0, en = 1'b0, we = 1'b0;
    logic [2:0]        addr = '0;
    logic [CW-1:0]     wdata = '0;
    logic [NC*DW-1:0]  din = '0;
    logic [NC*DW-1:0]  dout;
    logic [1:0]        flags;

    hblank_marker uut (
        .clk(clk), .rst_n(rst_n), .blank_in(blank), .sample_en(en),
        .cfg_we(we), .cfg_addr(addr), .cfg_wdata(wdata), .ch_in(din),
        .ch_out(dout), .flag_o(flags)
    );

    // Narrow instance for the saturation case.
    logic             s_rst_n = 1'b0, s_en = 1'b0, s_we = 1'b0;
    logic [2:0]       s_addr = '0;
    logic [DW-1:0]    s_wdata = '0;
    logic [NC*DW-1:0] s_dout;
    logic [1:0]       s_flags;

    hblank_marker #(.CNT_W(6)) uut_sat (
        .clk(clk), .rst_n(s_rst_n), .blank_in(1'b0), .sample_en(s_en),
        .cfg_we(s_we), .cfg_addr(s_addr), .cfg_wdata(s_wdata), .ch_in('0),
        .ch_out(s_dout), .flag_o(s_flags)
    );

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [1:0]       fl;
        logic [NC*DW-1:0] dat;
        string            tag;
    } exp_t;

    exp_t sb[$];
    exp_t cur;

    // Reference state derived from the requirements.
    logic [CW-1:0]    m_cnt = '0;
    logic [1:0]       m_flags = '0;
    logic [CW-1:0]    m_tc [2];
    logic [DW-1:0]    m_lvl [NC];
    logic             m_bq = 1'b0;
    logic [NC*DW-1:0] m_out = '0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Driver: one clock, update the model, queue the expected outputs.
    task automatic cyc(input string tag);
        logic       fall;
        logic [1:0] nf;
        logic [CW-1:0] nc;
        exp_t e;
        @(posedge clk);
        if (!rst_n) begin
            m_cnt = '0; m_flags = '0; m_bq = 1'b0; m_out = '0;
            for (int i = 0; i < 2; i++) m_tc[i] = MAXC;
            for (int c = 0; c < NC; c++) m_lvl[c] = '0;
        end else begin
            fall = m_bq && !blank;
            for (int i = 0; i < 2; i++)
                nf[i] = fall ? 1'b0 : (m_flags[i] | (m_cnt == m_tc[i]));
            nc = fall ? '0 : ((en && m_cnt != MAXC) ? m_cnt + 1'b1 : m_cnt);
            for (int c = 0; c < NC; c++)
                m_out[c*DW +: DW] = blank ? m_lvl[c] : din[c*DW +: DW];
            if (we) begin
                if (!addr[2] && addr[1:0] < 2) m_tc[addr[0]] = wdata;
                else if (addr[2]) m_lvl[addr[1:0]] = wdata[DW-1:0];
            end
            m_flags = nf; m_cnt = nc; m_bq = blank;
        end
        e.fl = m_flags; e.dat = m_out; e.tag = tag;
        sb.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [CW-1:0] d, input string tag);
        we = 1'b1; addr = a; wdata = d;
        cyc(tag);
        we = 1'b0;
    endtask

    task automatic run(input int n, input string tag, input logic gap);
        for (int k = 0; k < n; k++) begin
            din = din + 52'h0_9A3C_5E71_2B4D;
            if (gap) en = k[0];
            cyc(tag);
        end
    endtask

    // Monitor: compare queued expectations with the outputs.
    always @(negedge clk) begin
        if (sb.size() > 0) begin
            cur = sb.pop_front();
            chk({cur.tag, " flags"}, 64'(flags), 64'(cur.fl));
            chk({cur.tag, " data"}, 64'(dout), 64'(cur.dat));
        end
    end

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        @(negedge clk);
        cyc("R1 reset"); cyc("R1 reset");
        rst_n = 1'b1;
        en = 1'b1;
        wr(3'd0, 20'd5, "R8 tc0");
        wr(3'd1, 20'd9, "R8 tc1");
        blank = 1'b1;
        wr(3'd4, 20'h0040, "R10 lvl0");
        wr(3'd5, 20'h1000, "R10 lvl1");
        wr(3'd6, 20'h0ABC, "R10 lvl2");
        wr(3'd7, 20'h1FFF, "R10 lvl3");
        run(3, "R9 blank levels", 1'b0);
        blank = 1'b0;
        cyc("R5 clear");
        run(14, "R2 R3 markers", 1'b0);
        run(10, "R2 gapped samples", 1'b1);
        en = 1'b1;
        blank = 1'b1;
        run(4, "R6 blank rise no clear", 1'b0);
        wr(3'd0, 20'd0, "R8 write keeps flags");
        blank = 1'b0;
        cyc("R5 clear");
        run(4, "R2 tc zero", 1'b0);
        wr(3'd1, 20'd2, "R8 tc1 passed value");
        run(3, "R3 independent", 1'b0);
        wr(3'd2, 20'h1234, "R11 unused addr2");
        wr(3'd3, 20'h0777, "R11 unused addr3");
        blank = 1'b1;
        run(3, "R11 levels unchanged", 1'b0);
        blank = 1'b0;
        cyc("R5 clear");
        wr(3'd0, 20'd50, "R8 tc0 far");
        wr(3'd1, 20'd60, "R8 tc1 far");
        run(3, "R9 pass through", 1'b0);
        en = 1'b0;
        blank = 1'b1;
        wr(3'd0, m_cnt, "R5 match armed");
        blank = 1'b0;
        cyc("R5 clear beats match");
        cyc("R5 after clear");
        en = 1'b1;
        run(3, "R2 restart", 1'b0);
        while (sb.size() > 0) @(negedge clk);

        // Saturation on the 6-bit instance.
        s_rst_n = 1'b0;
        @(negedge clk); @(negedge clk);
        chk("R1 sat reset flags", 64'(s_flags), 64'd0);
        s_rst_n = 1'b1; s_en = 1'b1;
        repeat (50) @(negedge clk);
        s_we = 1'b1; s_addr = 3'd1; s_wdata = 13'd10;
        @(negedge clk);
        s_we = 1'b0;
        chk("R7 before saturation flag1", 64'(s_flags[1]), 64'd0);
        repeat (40) @(negedge clk);
        chk("R7 no wrap flag1", 64'(s_flags[1]), 64'd0);
        chk("R7 max reached flag0", 64'(s_flags[0]), 64'd1);
        s_we = 1'b1; s_addr = 3'd1; s_wdata = 13'd63;
        @(negedge clk);
        s_we = 1'b0;
        @(negedge clk);
        chk("R7 held at max flag1", 64'(s_flags[1]), 64'd1);
        finish_run();
    end

endmodule